// File: doc/BRIEF.md
# Edge-Selectable Interrupt Request Unit

This unit sits between a small CPU core and its interrupt sources. Four external pins, eight key-scan pins and three internal timer pulses come in. Each pin is passed through a two-flop synchronizer and then through a width filter: a new level counts only after it has held for `FILT_LEN` clock cycles. A qualified edge on a pin is then matched against that pin's edge rule. Pin 0 and pin 1 take a rule that software selects (rising or falling). Pin 2 reacts to rising edges only. Pin 3 reacts to both edges. The key-scan pins react to falling edges only. A matching edge sets a request flag.

The flags come in two kinds. Vectored flags belong to pins 0, 1 and 3 and to the three timer pulses. They pass through per-source enable bits into a priority encoder that drives a vector request. Polled flags belong to pin 2 and to the key-scan pins. They only record the event, which software reads and clears, and they never raise the vector request. Software reaches the enables, the edge modes and all flags through a four-word register port. A flag bit is cleared by writing 1 to it.

The vector output behaves like a valid/ready source. `vec_valid_o` stays high while any enabled vectored flag is pending. `vec_id_o` names the lowest-numbered such flag. The CPU accepts the vector by raising `vec_ack_i` (ready) in a cycle where valid is high, and that retires exactly the flag named in that cycle. There is no holding of the payload: if a lower-numbered source becomes pending before the acknowledge, `vec_id_o` moves to it.

Top module: `irq_edge_unit`

## Requirements
- R1: A pin level change is qualified only after it has been seen, past the two-flop synchronizer, for `FILT_LEN` (default 4) consecutive cycles. A pulse of `FILT_LEN-1` cycles sets no flag.
- R2: In register 3, bit 0 selects the edge for pin 0 and bit 1 selects the edge for pin 1 (0 = rising, 1 = falling). A qualified matching edge sets vectored flag 0 or 1. The opposite edge is ignored.
- R3: A qualified rising edge on pin 2 sets polled flag bit 4 of register 3. A falling edge on pin 2 does not set it, and the flag never raises `vec_valid_o`.
- R4: Both qualified rising and qualified falling edges on pin 3 set vectored flag 2.
- R5: A qualified falling edge on key pin k sets bit k of register 2. A rising edge does not set it, and these flags never raise `vec_valid_o`.
- R6: A one-cycle pulse on timer input j sets vectored flag 3+j at the next clock edge.
- R7: Register 0 bits 5:0 enable vectored flags 5:0 toward the vector request. A disabled flag still sets and still reads back in register 1.
- R8: `vec_valid_o` is high when any enabled vectored flag is set, and `vec_id_o` is then the lowest-numbered such flag.
- R9: `vec_ack_i` high while `vec_valid_o` is high clears only the flag named by `vec_id_o`.
- R10: Writing 1 to a flag bit of register 1, 2 or register 3 bit 4 clears that flag, and writing 0 leaves it. A set in the same cycle as a clear leaves the flag set.
- R11: After reset all flags, enables and edge modes read 0 and `vec_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin_i | input | 4 | External pins: 0,1 selectable edge; 2 rising polled; 3 both edges |
| key_pin_i | input | N_KEY | Key-scan pins, falling edge, polled |
| tmr_pulse_i | input | N_TMR | Internal timer request pulses |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 enable, 1 vectored flags, 2 key flags, 3 mode and pin-2 flag |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` |
| vec_valid_o | output | 1 | Vector request pending |
| vec_id_o | output | 3 | Winning vector number |
| vec_ack_i | input | 1 | Vector accepted (ready) |

## Verification
Pin 3 is driven with a pulse one cycle short of the filter length and then with one of exactly the filter length, which shows where the filter's threshold lies. Each edge-rule source gets both a rising and a falling edge, and pin 0 gets them in both modes, so a wrong polarity or a missing edge rule shows up as a wrong flag. Two timer pulses in the same cycle, and then a pin edge together with a timer pulse, test the winning order and show that an acknowledge retires only the winner. Enable masking, a write of zeros, and a write-clear in the same cycle as a new pulse test the clear rules apart from the set path.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int REG_W = 8;
  localparam logic [1:0] ADDR_EN   = 2'd0;
  localparam logic [1:0] ADDR_VFLG = 2'd1;
  localparam logic [1:0] ADDR_KFLG = 2'd2;
  localparam logic [1:0] ADDR_MODE = 2'd3;
  localparam int QZ_BIT = 4;
  typedef enum logic {EDGE_RISE = 1'b0, EDGE_FALL = 1'b1} edge_sel_e;
endpackage

// File: rtl/irq_pin_qual.sv
module irq_pin_qual #(
  parameter int   FILT_LEN = 4,
  parameter logic RST_LVL  = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [CW-1:0] CNT_MAX = CW'(FILT_LEN - 1);

  logic [1:0]    sync_q;
  logic          level_q;
  logic [CW-1:0] cnt_q;
  logic          seen;
  logic          update;

  assign seen   = sync_q[1];
  assign update = (seen != level_q) && (cnt_q == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= {2{RST_LVL}};
      level_q <= RST_LVL;
      cnt_q   <= '0;
      rise_o  <= 1'b0;
      fall_o  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], pin_i};
      rise_o <= update & seen;
      fall_o <= update & ~seen;
      if (seen == level_q) begin
        cnt_q <= '0;
      end else if (update) begin
        level_q <= seen;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R1
  filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level_q) |-> $past(cnt_q) == CNT_MAX);
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_o <= '0;
    else        flag_o <= (flag_o & ~clr_i) | set_i;
  end

  for (genvar b = 0; b < N; b++) begin : g_chk
    // R10
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[b] |=> flag_o[b]);
    // R10
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i[b] && !set_i[b] |=> !flag_o[b]);
  end
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int N  = 6,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req_i,
  output logic          valid_o,
  output logic [IW-1:0] id_o,
  output logic [N-1:0]  grant_o
);
  always_comb begin
    id_o    = '0;
    grant_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        id_o    = IW'(i);
        grant_o = N'(1) << i;
      end
    end
    valid_o = |req_i;
  end

  // R8
  always_comb begin
    if (valid_o) begin
      prio_win_chk: assert ((req_i & ((N'(1) << id_o) - N'(1))) == '0 && req_i[id_o]);
    end
  end
endmodule

// File: rtl/irq_edge_unit.sv
module irq_edge_unit
  import irq_pkg::*;
#(
  parameter int N_KEY    = 8,
  parameter int N_TMR    = 3,
  parameter int FILT_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       ext_pin_i,
  input  logic [N_KEY-1:0] key_pin_i,
  input  logic [N_TMR-1:0] tmr_pulse_i,
  input  logic             reg_wr_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             vec_valid_o,
  output logic [2:0]       vec_id_o,
  input  logic             vec_ack_i
);
  localparam int N_VEC = 3 + N_TMR;
  localparam int IW    = 3;

  logic [3:0]       ext_rise, ext_fall;
  logic [N_KEY-1:0] key_rise, key_fall;
  logic [1:0]       mode_q;
  logic [N_VEC-1:0] en_q, vflag, vset, vclr, grant;
  logic [N_KEY-1:0] kflag, kclr;
  logic [0:0]       qflag, qclr;
  logic [1:0]       sel_hit;
  logic             wr_en, wr_vf, wr_kf, wr_md;

  for (genvar p = 0; p < 4; p++) begin : g_ext
    irq_pin_qual #(.FILT_LEN(FILT_LEN), .RST_LVL(1'b0)) u_q (
      .clk(clk), .rst_n(rst_n), .pin_i(ext_pin_i[p]),
      .rise_o(ext_rise[p]), .fall_o(ext_fall[p]));
  end

  for (genvar k = 0; k < N_KEY; k++) begin : g_key
    irq_pin_qual #(.FILT_LEN(FILT_LEN), .RST_LVL(1'b1)) u_q (
      .clk(clk), .rst_n(rst_n), .pin_i(key_pin_i[k]),
      .rise_o(key_rise[k]), .fall_o(key_fall[k]));
  end

  for (genvar s = 0; s < 2; s++) begin : g_sel
    assign sel_hit[s] = (mode_q[s] == EDGE_FALL) ? ext_fall[s] : ext_rise[s];
  end

  assign wr_en = reg_wr_i && reg_addr_i == ADDR_EN;
  assign wr_vf = reg_wr_i && reg_addr_i == ADDR_VFLG;
  assign wr_kf = reg_wr_i && reg_addr_i == ADDR_KFLG;
  assign wr_md = reg_wr_i && reg_addr_i == ADDR_MODE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mode_q <= '0;
    end else begin
      if (wr_en) en_q   <= reg_wdata_i[N_VEC-1:0];
      if (wr_md) mode_q <= reg_wdata_i[1:0];
    end
  end

  assign vset = {tmr_pulse_i, ext_rise[3] | ext_fall[3], sel_hit};
  assign vclr = (wr_vf ? reg_wdata_i[N_VEC-1:0] : '0)
              | ((vec_ack_i && vec_valid_o) ? grant : '0);
  assign kclr = wr_kf ? reg_wdata_i[N_KEY-1:0] : '0;
  assign qclr = wr_md ? reg_wdata_i[QZ_BIT] : 1'b0;

  irq_flag_bank #(.N(N_VEC)) u_vflags (
    .clk(clk), .rst_n(rst_n), .set_i(vset), .clr_i(vclr), .flag_o(vflag));
  irq_flag_bank #(.N(N_KEY)) u_kflags (
    .clk(clk), .rst_n(rst_n), .set_i(key_fall), .clr_i(kclr), .flag_o(kflag));
  irq_flag_bank #(.N(1)) u_qflag (
    .clk(clk), .rst_n(rst_n), .set_i(ext_rise[2]), .clr_i(qclr), .flag_o(qflag));

  irq_prio #(.N(N_VEC), .IW(IW)) u_prio (
    .req_i(vflag & en_q), .valid_o(vec_valid_o), .id_o(vec_id_o), .grant_o(grant));

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADDR_EN:   reg_rdata_o[N_VEC-1:0] = en_q;
      ADDR_VFLG: reg_rdata_o[N_VEC-1:0] = vflag;
      ADDR_KFLG: reg_rdata_o[N_KEY-1:0] = kflag;
      default: begin
        reg_rdata_o[1:0]    = mode_q;
        reg_rdata_o[QZ_BIT] = qflag[0];
      end
    endcase
  end

  // R9
  ack_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_ack_i && vec_valid_o |=> !vflag[$past(vec_id_o)] || $past(vset[vec_id_o]));
endmodule

// File: tb/test_irq_edge_unit.sv
module test_irq_edge_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ext_pin = '0;
  logic [7:0] key_pin = '1;
  logic [2:0] tmr = '0;
  logic       wr = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       vvalid;
  logic [2:0] vid;
  logic       ack = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int    q_kind[$];
  int    q_exp[$];
  string q_tag[$];
  event  smp;

  always #10 clk = ~clk;

  irq_edge_unit i_irq_edge_unit (
    .clk(clk), .rst_n(rst_n), .ext_pin_i(ext_pin), .key_pin_i(key_pin),
    .tmr_pulse_i(tmr), .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .vec_valid_o(vvalid), .vec_id_o(vid), .vec_ack_i(ack));

  // monitor: pops expected items and compares with the outputs
  initial begin
    forever begin
      int k, e, act;
      string t;
      @(smp);
      k = q_kind.pop_front();
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      act = (k == 0) ? int'(rdata) : (vvalid ? (8 | int'(vid)) : 0);
      checks++;
      if (act != e) begin
        errors++;
        $display("FAIL %s actual 0x%0h expected 0x%0h", t, act, e);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic exp_reg(logic [1:0] a, int e, string t);
    addr = a;
    q_kind.push_back(0); q_exp.push_back(e); q_tag.push_back(t);
    #1 -> smp;
    #1;
  endtask

  // e: 0 for no request, else 8 | id
  task automatic exp_vec(int e, string t);
    q_kind.push_back(1); q_exp.push_back(e); q_tag.push_back(t);
    #1 -> smp;
    #1;
  endtask

  task automatic wr_reg(logic [1:0] a, logic [7:0] d);
    wr = 1'b1; addr = a; wdata = d;
    cyc(1);
    wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R11 reset state
    exp_reg(0, 0, "R11 enable");
    exp_reg(1, 0, "R11 vflags");
    exp_reg(2, 0, "R11 kflags");
    exp_reg(3, 0, "R11 mode");
    exp_vec(0, "R11 valid");

    // R1 short pulse on both-edge pin rejected, full-length accepted
    ext_pin[3] = 1'b1; cyc(3); ext_pin[3] = 1'b0; cyc(10);
    exp_reg(1, 0, "R1 short pulse");
    ext_pin[3] = 1'b1; cyc(4); ext_pin[3] = 1'b0; cyc(10);
    exp_reg(1, 8'h04, "R1 full pulse");
    wr_reg(1, 8'h04);
    exp_reg(1, 0, "R10 w1c");

    // R4 each edge of pin 3 alone
    ext_pin[3] = 1'b1; cyc(10);
    exp_reg(1, 8'h04, "R4 rise");
    wr_reg(1, 8'h04);
    ext_pin[3] = 1'b0; cyc(10);
    exp_reg(1, 8'h04, "R4 fall");
    wr_reg(1, 8'h04);

    // R2 pin 0 rising mode, then falling mode
    ext_pin[0] = 1'b1; cyc(10);
    exp_reg(1, 8'h01, "R2 p0 rise mode rise");
    wr_reg(1, 8'h01);
    ext_pin[0] = 1'b0; cyc(10);
    exp_reg(1, 0, "R2 p0 rise mode fall");
    wr_reg(3, 8'h01);
    exp_reg(3, 8'h01, "R2 mode readback");
    ext_pin[0] = 1'b1; cyc(10);
    exp_reg(1, 0, "R2 p0 fall mode rise");
    ext_pin[0] = 1'b0; cyc(10);
    exp_reg(1, 8'h01, "R2 p0 fall mode fall");
    wr_reg(1, 8'h01);
    wr_reg(3, 8'h02);
    ext_pin[1] = 1'b1; cyc(10);
    exp_reg(1, 0, "R2 p1 fall mode rise");
    ext_pin[1] = 1'b0; cyc(10);
    exp_reg(1, 8'h02, "R2 p1 fall mode fall");
    wr_reg(1, 8'h02);
    wr_reg(3, 8'h00);

    // R3 pin 2 polled, rising only
    wr_reg(0, 8'h3F);
    ext_pin[2] = 1'b1; cyc(10);
    exp_reg(3, 8'h10, "R3 rise sets");
    exp_vec(0, "R3 no vector");
    wr_reg(3, 8'h10);
    ext_pin[2] = 1'b0; cyc(10);
    exp_reg(3, 0, "R3 fall ignored");

    // R5 key pin falling only
    key_pin[5] = 1'b0; cyc(10);
    exp_reg(2, 8'h20, "R5 fall sets");
    exp_vec(0, "R5 no vector");
    wr_reg(2, 8'h20);
    key_pin[5] = 1'b1; cyc(10);
    exp_reg(2, 0, "R5 rise ignored");

    // R6 R8 R9 two timer pulses together
    tmr = 3'b110; cyc(1); tmr = '0;
    exp_reg(1, 8'h30, "R6 timer flags");
    exp_vec(8 | 4, "R8 lowest wins");
    ack = 1'b1; cyc(1); ack = 1'b0;
    exp_reg(1, 8'h20, "R9 ack retires winner only");
    exp_vec(8 | 5, "R9 next vector");
    ack = 1'b1; cyc(1); ack = 1'b0;
    exp_vec(0, "R9 all retired");

    // R8 pin source beats timer
    ext_pin[0] = 1'b1; tmr = 3'b001; cyc(1); tmr = '0; cyc(10);
    exp_reg(1, 8'h09, "R8 pin and timer");
    exp_vec(8 | 0, "R8 pin 0 wins");

    // R7 enable masking
    wr_reg(0, 8'h3E);
    exp_vec(8 | 3, "R7 masked source skipped");
    wr_reg(0, 8'h00);
    exp_vec(0, "R7 all masked");
    exp_reg(1, 8'h09, "R7 flags still held");
    wr_reg(1, 8'h09);

    // R10 set wins over clear, zero write leaves flag
    tmr = 3'b001; cyc(1); tmr = '0;
    wr = 1'b1; addr = 2'd1; wdata = 8'h08; tmr = 3'b001;
    cyc(1);
    wr = 1'b0; tmr = '0;
    exp_reg(1, 8'h08, "R10 set beats clear");
    wr_reg(1, 8'h00);
    exp_reg(1, 8'h08, "R10 zero write keeps");
    wr_reg(1, 8'h08);
    exp_reg(1, 0, "R10 clear");

    cyc(2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule